// File: doc/BRIEF.md
# Slice Clock and Qualifier Selector

This block sits beside one serial shift slice in a sixteen-slice serial GPIO engine. Its job is to decide when the slice shifts. It produces a single-cycle shift strobe in the fast engine clock domain. The strobe can come from two places. One is a free-running programmable divider inside the engine. The other is an external clock, taken either from one of four pins or from one of four neighbouring slices.

An external clock is never used as a real clock. It is oversampled through a two-flop synchronizer, and a registered history bit turns it into a rising-edge or falling-edge event. Every event is gated by a qualifier, which can be:
- always on,
- a synchronized pin, or
- another slice's qualifier output.

The slice position is set by a parameter. Slices A to P are numbered 0 to 15, so A=0, D=3, H=7, I=8, O=14 and P=15. The parameter fixes two wiring rules:
- Slices that can themselves drive a clock may not take their clock from a slice.
- A slice whose own qualifier sits in the slice-qualifier list gets a fixed neighbour in its place.

Top module: `slice_clkq_sel`

## Requirements
- R1: While `rst_n` is low, `shift_strobe` is 0. The synchronizer and edge-history flops reset to 0, so in external rising mode with the selected clock held low, no strobe follows reset.
- R2: With `cfg_clk_from_slice`=0, the external clock is `pin_in[cfg_clk_idx]`. With it at 1, the clock is `clk_tap[cfg_clk_idx]`, where tap index 0..3 carries the clock of slice D, H, O, P in that order.
- R3: When the parameter `SLICE_ID` is 3, 7, 14 or 15 (a clock-driving slice), `cfg_clk_from_slice` is ignored and the clock is always `pin_in[cfg_clk_idx]`.
- R4: Suppose the selected clock is sampled by the rising edge k of `clk` as a changed value. Then `shift_strobe` is high for exactly the one cycle that begins at edge k+2.
- R5: `cfg_fall_edge`=0 makes events on 0-to-1 transitions of the synchronized clock. `cfg_fall_edge`=1 makes them on 1-to-0 transitions. Two events of the same polarity are never on adjacent cycles.
- R6: `cfg_qual_mode` selects the qualifier:
  - 0 and 3: always true.
  - 1: `pin_in[cfg_qual_idx]`, through a two-flop synchronizer, so it aligns with a clock taken from a pin.
  - 2: `qual_tap[cfg_qual_idx]` used directly, with tap index 0..3 meaning slice A, H, I, P.
- R7: In mode 2, when the chosen tap is the slice itself, a substitute is used: `sub_qual_tap[0]` (slice D) for slices A (0) and I (8), and `sub_qual_tap[1]` (slice O) for slices H (7) and P (15).
- R8: With `cfg_ext_clk`=0, events come from a down-counter that resets to 0. The counter raises an event whenever it is 0, then reloads `cfg_div_preset`, so events repeat every preset+1 cycles. The external clock has no effect in this mode.
- R9: A strobe is produced only when the qualifier is true in the same cycle as the event, in both internal and external mode.
- R10: Mode, polarity, qualifier and divider settings are sampled on each rising edge of `clk`. A change therefore takes effect on the strobe of the next cycle.
- R11: Clock edges spaced two or more cycles apart are each detected. A clock that toggles every two cycles gives one strobe per rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 4 | Pins usable as clock or qualifier (pin numbers 8..11) |
| clk_tap | input | 4 | Clock outputs of slices D, H, O, P |
| qual_tap | input | 4 | Qualifier outputs of slices A, H, I, P |
| sub_qual_tap | input | 2 | Substitute qualifiers: [0] slice D, [1] slice O |
| cfg_ext_clk | input | 1 | 1 = external clock, 0 = internal divider |
| cfg_clk_from_slice | input | 1 | 1 = clock from a slice tap, 0 = from a pin |
| cfg_clk_idx | input | 2 | Clock source index |
| cfg_fall_edge | input | 1 | 1 = falling-edge events |
| cfg_qual_mode | input | 2 | Qualifier mode |
| cfg_qual_idx | input | 2 | Qualifier source index |
| cfg_div_preset | input | 8 | Divider reload value |
| shift_strobe | output | 1 | One-cycle shift enable |

## Verification
The bench places two instances side by side:
- a clock-driving slice H, which has a self-qualifier substitute, and
- an ordinary slice B.

Both are checked against a behavioural model. It looks for:
- an off-by-one in the synchronizer latency, which would shift every strobe by a cycle in the latency probe;
- a pin qualifier that is not delayed with the clock, which would let strobes through on falling edges in the aligned-waveform test;
- a slice that reads its own qualifier or takes a slice clock when it may not, which shows up as strobes where a count of zero is expected.

Divider period errors and a counter that reloads off by one would change the strobe count over a fixed window. Random configuration changes on every cycle expose any setting that is applied a cycle early or late.

// File: rtl/slice_clkq_pkg.sv
package slice_clkq_pkg;

    localparam int SLICE_COUNT = 16;

    localparam int SL_A = 0;
    localparam int SL_D = 3;
    localparam int SL_H = 7;
    localparam int SL_I = 8;
    localparam int SL_O = 14;
    localparam int SL_P = 15;

    typedef enum logic [1:0] {
        QM_ALWAYS = 2'd0,
        QM_PIN    = 2'd1,
        QM_SLICE  = 2'd2,
        QM_SPARE  = 2'd3
    } qual_mode_e;

    // Slices whose own output is a clock tap for others.
    function automatic bit is_clock_driver(int id);
        return (id == SL_D) || (id == SL_H) || (id == SL_O) || (id == SL_P);
    endfunction

    // Owner slice of each qualifier tap position.
    function automatic int qual_tap_owner(int idx);
        case (idx)
            0:       return SL_A;
            1:       return SL_H;
            2:       return SL_I;
            default: return SL_P;
        endcase
    endfunction

    // Tap position that would loop the slice onto itself, or -1.
    function automatic int self_qual_pos(int id);
        for (int k = 0; k < 4; k++) begin
            if (qual_tap_owner(k) == id) return k;
        end
        return -1;
    endfunction

    // 0 selects the slice-D substitute, 1 the slice-O substitute.
    function automatic int substitute_sel(int id);
        return ((id == SL_H) || (id == SL_P)) ? 1 : 0;
    endfunction

endpackage

// File: rtl/slice_sync.sv
module slice_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.chain[STAGES-1];

endmodule

// File: rtl/slice_clk_mux.sv
module slice_clk_mux
    import slice_clkq_pkg::*;
#(
    parameter int SLICE_ID = 0,
    parameter int NUM_SRC  = 4,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pin_in,
    input  logic [NUM_SRC-1:0] clk_tap,
    input  logic               from_slice,
    input  logic [IDX_W-1:0]   src_idx,
    output logic               sel_clk
);

    generate
        if (is_clock_driver(SLICE_ID)) begin : g_pin_only
            // A clock-driving slice may not be clocked by any slice.
            logic unused_taps;
            assign unused_taps = ^{clk_tap, from_slice};
            assign sel_clk     = pin_in[src_idx];
        end else begin : g_pin_or_tap
            assign sel_clk = from_slice ? clk_tap[src_idx] : pin_in[src_idx];
        end
    endgenerate

endmodule

// File: rtl/slice_edge_det.sv
module slice_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_clk,
    input  logic fall_sel,
    output logic ext_edge
);

    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        cur;

    slice_sync #(
        .WIDTH (1),
        .STAGES(SYNC_STAGES)
    ) clk_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(raw_clk),
        .sync_out(cur)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ext_edge = fall_sel ? (st_q.prev & ~cur) : (~st_q.prev & cur);

endmodule

// File: rtl/slice_div.sv
module slice_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] preset,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    assign tick = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cnt = preset;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/slice_qual_sel.sv
module slice_qual_sel
    import slice_clkq_pkg::*;
#(
    parameter int SLICE_ID    = 0,
    parameter int NUM_SRC     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pin_in,
    input  logic [NUM_SRC-1:0] qual_tap,
    input  logic [1:0]         sub_tap,
    input  logic [1:0]         mode,
    input  logic [IDX_W-1:0]   src_idx,
    output logic [NUM_SRC-1:0] pin_sync,
    output logic               slice_qual,
    output logic               qual_ok
);

    localparam int SELF_POS = self_qual_pos(SLICE_ID);
    localparam int SUB_SEL  = substitute_sel(SLICE_ID);

    slice_sync #(
        .WIDTH (NUM_SRC),
        .STAGES(SYNC_STAGES)
    ) pin_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pin_in),
        .sync_out(pin_sync)
    );

    generate
        if (SELF_POS >= 0) begin : g_substitute
            always_comb begin
                if (int'(src_idx) == SELF_POS) begin
                    slice_qual = sub_tap[SUB_SEL];
                end else begin
                    slice_qual = qual_tap[src_idx];
                end
            end
        end else begin : g_direct
            logic unused_sub;
            assign unused_sub = ^sub_tap;
            assign slice_qual = qual_tap[src_idx];
        end
    endgenerate

    always_comb begin
        case (qual_mode_e'(mode))
            QM_PIN:   qual_ok = pin_sync[src_idx];
            QM_SLICE: qual_ok = slice_qual;
            default:  qual_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/slice_clkq_sel.sv
module slice_clkq_sel
    import slice_clkq_pkg::*;
#(
    parameter int SLICE_ID    = 0,
    parameter int NUM_SRC     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 8,
    localparam int IDX_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pin_in,
    input  logic [NUM_SRC-1:0] clk_tap,
    input  logic [NUM_SRC-1:0] qual_tap,
    input  logic [1:0]         sub_qual_tap,
    input  logic               cfg_ext_clk,
    input  logic               cfg_clk_from_slice,
    input  logic [IDX_W-1:0]   cfg_clk_idx,
    input  logic               cfg_fall_edge,
    input  logic [1:0]         cfg_qual_mode,
    input  logic [IDX_W-1:0]   cfg_qual_idx,
    input  logic [DIV_W-1:0]   cfg_div_preset,
    output logic               shift_strobe
);

    typedef struct packed {
        logic strobe;
    } top_state_t;

    top_state_t         st_d, st_q;
    logic               sel_clk;
    logic               ext_edge;
    logic               div_tick;
    logic               qual_ok;
    logic               slice_qual;
    logic [NUM_SRC-1:0] qual_pin_sync;

    slice_clk_mux #(
        .SLICE_ID(SLICE_ID),
        .NUM_SRC (NUM_SRC)
    ) clk_mux_i (
        .pin_in    (pin_in),
        .clk_tap   (clk_tap),
        .from_slice(cfg_clk_from_slice),
        .src_idx   (cfg_clk_idx),
        .sel_clk   (sel_clk)
    );

    slice_edge_det #(
        .SYNC_STAGES(SYNC_STAGES)
    ) edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_clk (sel_clk),
        .fall_sel(cfg_fall_edge),
        .ext_edge(ext_edge)
    );

    slice_div #(
        .DIV_W(DIV_W)
    ) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .preset(cfg_div_preset),
        .tick  (div_tick)
    );

    slice_qual_sel #(
        .SLICE_ID   (SLICE_ID),
        .NUM_SRC    (NUM_SRC),
        .SYNC_STAGES(SYNC_STAGES)
    ) qual_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .qual_tap  (qual_tap),
        .sub_tap   (sub_qual_tap),
        .mode      (cfg_qual_mode),
        .src_idx   (cfg_qual_idx),
        .pin_sync  (qual_pin_sync),
        .slice_qual(slice_qual),
        .qual_ok   (qual_ok)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = (cfg_ext_clk ? ext_edge : div_tick) & qual_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_strobe = st_q.strobe;

endmodule

// File: rtl/slice_clkq_sel_chk.sv
module slice_clkq_sel_chk
    import slice_clkq_pkg::*;
#(
    parameter int SLICE_ID = 0,
    parameter int NUM_SRC  = 4,
    parameter int DIV_W    = 8,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] pin_in,
    input logic [1:0]         sub_qual_tap,
    input logic               cfg_ext_clk,
    input logic [IDX_W-1:0]   cfg_clk_idx,
    input logic               cfg_fall_edge,
    input logic [1:0]         cfg_qual_mode,
    input logic [IDX_W-1:0]   cfg_qual_idx,
    input logic [DIV_W-1:0]   cfg_div_preset,
    input logic               shift_strobe,
    input logic               sel_clk,
    input logic               ext_edge,
    input logic               div_tick,
    input logic               slice_qual,
    input logic [NUM_SRC-1:0] qual_pin_sync
);

    localparam int SELF_POS = self_qual_pos(SLICE_ID);
    localparam int SUB_SEL  = substitute_sel(SLICE_ID);

    logic unused_chk;
    assign unused_chk = ^{pin_in, sub_qual_tap, cfg_clk_idx, sel_clk, slice_qual};

    // R2: external mode without an edge gives no strobe next cycle
    a_r2_ext_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ext_clk && !ext_edge) |=> !shift_strobe);

    // R8: internal mode without a divider tick gives no strobe
    a_r8_int_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ext_clk && !div_tick) |=> !shift_strobe);

    // R8: after a tick the counter reloads, so a back-to-back tick needs preset zero
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |=> (!div_tick || ($past(cfg_div_preset) == '0)));

    // R5: same-polarity events are never adjacent
    a_r5_edge_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ext_edge |=> (!ext_edge || (cfg_fall_edge != $past(cfg_fall_edge))));

    // R9: a low synchronized pin qualifier blocks the strobe
    a_r9_pin_qual_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_qual_mode == 2'd1) && !qual_pin_sync[cfg_qual_idx]) |=> !shift_strobe);

    generate
        if (is_clock_driver(SLICE_ID)) begin : g_r3
            // R3: clock-driving slices always take the pin
            a_r3_pin_only: assert property (@(posedge clk) disable iff (!rst_n)
                sel_clk == pin_in[cfg_clk_idx]);
        end
        if (SELF_POS >= 0) begin : g_r7
            // R7: own qualifier position maps onto the fixed substitute
            a_r7_substitute: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(cfg_qual_idx) == SELF_POS) |-> (slice_qual == sub_qual_tap[SUB_SEL]));
        end
    endgenerate

endmodule

bind slice_clkq_sel slice_clkq_sel_chk #(
    .SLICE_ID(SLICE_ID),
    .NUM_SRC (NUM_SRC),
    .DIV_W   (DIV_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_in        (pin_in),
    .sub_qual_tap  (sub_qual_tap),
    .cfg_ext_clk   (cfg_ext_clk),
    .cfg_clk_idx   (cfg_clk_idx),
    .cfg_fall_edge (cfg_fall_edge),
    .cfg_qual_mode (cfg_qual_mode),
    .cfg_qual_idx  (cfg_qual_idx),
    .cfg_div_preset(cfg_div_preset),
    .shift_strobe  (shift_strobe),
    .sel_clk       (sel_clk),
    .ext_edge      (ext_edge),
    .div_tick      (div_tick),
    .slice_qual    (slice_qual),
    .qual_pin_sync (qual_pin_sync)
);

// File: tb/slice_clkq_sel_tb_top.sv
`timescale 1ns/1ps
module slice_clkq_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_in = '0;
    logic [3:0] clk_tap = '0;
    logic [3:0] qual_tap = '0;
    logic [1:0] sub_qual_tap = '0;
    logic       cfg_ext_clk = 1'b1;
    logic       cfg_clk_from_slice = 1'b0;
    logic [1:0] cfg_clk_idx = '0;
    logic       cfg_fall_edge = 1'b0;
    logic [1:0] cfg_qual_mode = '0;
    logic [1:0] cfg_qual_idx = '0;
    logic [7:0] cfg_div_preset = 8'd3;
    logic       strobe_h;
    logic       strobe_b;

    int    checks = 0;
    int    failures = 0;
    int    cnt_h = 0;
    int    cnt_b = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    // slice H (7): clock driver with a self-qualifier substitute
    slice_clkq_sel #(.SLICE_ID(7)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .clk_tap(clk_tap),
        .qual_tap(qual_tap), .sub_qual_tap(sub_qual_tap),
        .cfg_ext_clk(cfg_ext_clk), .cfg_clk_from_slice(cfg_clk_from_slice),
        .cfg_clk_idx(cfg_clk_idx), .cfg_fall_edge(cfg_fall_edge),
        .cfg_qual_mode(cfg_qual_mode), .cfg_qual_idx(cfg_qual_idx),
        .cfg_div_preset(cfg_div_preset), .shift_strobe(strobe_h));

    // slice B (1): ordinary slice
    slice_clkq_sel #(.SLICE_ID(1)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .clk_tap(clk_tap),
        .qual_tap(qual_tap), .sub_qual_tap(sub_qual_tap),
        .cfg_ext_clk(cfg_ext_clk), .cfg_clk_from_slice(cfg_clk_from_slice),
        .cfg_clk_idx(cfg_clk_idx), .cfg_fall_edge(cfg_fall_edge),
        .cfg_qual_mode(cfg_qual_mode), .cfg_qual_idx(cfg_qual_idx),
        .cfg_div_preset(cfg_div_preset), .shift_strobe(strobe_b));

    // ---------------- behavioural reference model ----------------
    int   ids[2] = '{7, 1};
    bit   ch[2][3];
    bit   [3:0] qh[2][2];
    int   dcnt[2];
    bit   expv[2];

    function automatic bit m_clk(int id);
        bit driver = (id == 3) || (id == 7) || (id == 14) || (id == 15);
        if (cfg_clk_from_slice && !driver) return clk_tap[cfg_clk_idx];
        return pin_in[cfg_clk_idx];
    endfunction

    function automatic bit m_slice_q(int id);
        int owner;
        case (cfg_qual_idx)
            2'd0: owner = 0;
            2'd1: owner = 7;
            2'd2: owner = 8;
            default: owner = 15;
        endcase
        if (owner != id) return qual_tap[cfg_qual_idx];
        if (id == 0 || id == 8) return sub_qual_tap[0];
        return sub_qual_tap[1];
    endfunction

    always @(posedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (!rst_n) begin
                ch[d] = '{0, 0, 0};
                qh[d] = '{4'h0, 4'h0};
                dcnt[d] = 0;
                expv[d] = 0;
            end else begin
                bit ev;
                bit q;
                if (cfg_ext_clk)
                    ev = cfg_fall_edge ? (ch[d][2] && !ch[d][1]) : (!ch[d][2] && ch[d][1]);
                else
                    ev = (dcnt[d] == 0);
                case (cfg_qual_mode)
                    2'd1: q = qh[d][1][cfg_qual_idx];
                    2'd2: q = m_slice_q(ids[d]);
                    default: q = 1;
                endcase
                expv[d] = ev && q;
                ch[d][2] = ch[d][1];
                ch[d][1] = ch[d][0];
                ch[d][0] = m_clk(ids[d]);
                qh[d][1] = qh[d][0];
                qh[d][0] = pin_in;
                dcnt[d] = (dcnt[d] == 0) ? int'(cfg_div_preset) : dcnt[d] - 1;
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one cycle: wait for the falling edge, compare against the model
    task automatic cyc();
        @(negedge clk);
        chk_bit(cur_req, "slice H strobe vs model", strobe_h, expv[0]);
        chk_bit(cur_req, "slice B strobe vs model", strobe_b, expv[1]);
        if (strobe_h === 1'b1) cnt_h++;
        if (strobe_b === 1'b1) cnt_b++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    // toggle masked pin and tap bits every `half` cycles, then settle
    task automatic toggle(int half, int n_tog, bit [3:0] pmask, bit [3:0] tmask);
        cnt_h = 0;
        cnt_b = 0;
        for (int t = 0; t < n_tog; t++) begin
            pin_in  = pin_in ^ pmask;
            clk_tap = clk_tap ^ tmask;
            idle(half);
        end
        idle(6);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL all-requirements watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset holds the strobe low
        cur_req = "R1";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk_bit("R1", "strobe during reset (H)", strobe_h, 1'b0);
            chk_bit("R1", "strobe during reset (B)", strobe_b, 1'b0);
        end
        rst_n = 1'b1;
        cnt_h = 0;
        idle(6);
        chk_int("R1", "strobes after reset with clock low", cnt_h, 0);

        // R4: latency probe, pin 0 rises once
        cur_req = "R4";
        pin_in[0] = 1'b1;
        cyc(); chk_bit("R4", "strobe 1 cycle after", strobe_h, 1'b0);
        cyc(); chk_bit("R4", "strobe 2 cycles after", strobe_h, 1'b0);
        cyc(); chk_bit("R4", "strobe 3 cycles after", strobe_h, 1'b1);
        cyc(); chk_bit("R4", "strobe 4 cycles after", strobe_h, 1'b0);
        pin_in[0] = 1'b0;
        idle(6);

        // R2 / R11: pin clock toggling every 2 cycles, 10 rising edges
        cur_req = "R11";
        toggle(2, 20, 4'b0001, 4'b0000);
        chk_int("R11", "rising strobes, 2-cycle half period", cnt_h, 10);
        chk_int("R2", "pin clock on ordinary slice", cnt_b, 10);

        // R2 / R3: clock from slice tap 1; pin 1 stays low
        cur_req = "R3";
        cfg_clk_from_slice = 1'b1;
        cfg_clk_idx = 2'd1;
        idle(4);
        toggle(2, 20, 4'b0000, 4'b0010);
        chk_int("R3", "clock-driving slice ignores tap clock", cnt_h, 0);
        chk_int("R2", "ordinary slice uses tap clock", cnt_b, 10);
        cfg_clk_from_slice = 1'b0;
        cfg_clk_idx = 2'd0;
        idle(4);

        // R5: falling polarity, pin toggling every 3 cycles
        cur_req = "R5";
        cfg_fall_edge = 1'b1;
        idle(4);
        toggle(3, 12, 4'b0001, 4'b0000);
        chk_int("R5", "falling-edge strobes", cnt_h, 6);

        // R6: pin qualifier identical to pin clock -> aligned
        cur_req = "R6";
        cfg_qual_mode = 2'd1;
        cfg_qual_idx = 2'd2;
        cfg_fall_edge = 1'b0;
        idle(4);
        toggle(2, 20, 4'b0101, 4'b0000);
        chk_int("R6", "qualifier aligned on rising edges", cnt_h, 10);
        cfg_fall_edge = 1'b1;
        idle(4);
        toggle(2, 20, 4'b0101, 4'b0000);
        chk_int("R9", "qualifier low on falling edges", cnt_h, 0);
        cfg_fall_edge = 1'b0;

        // R7: slice qualifier, tap 1 is slice H itself
        cur_req = "R7";
        cfg_qual_mode = 2'd2;
        cfg_qual_idx = 2'd1;
        cfg_clk_idx = 2'd1;
        qual_tap = 4'b0010;
        sub_qual_tap = 2'b00;
        idle(4);
        toggle(2, 20, 4'b0010, 4'b0010);
        chk_int("R7", "self tap replaced by low substitute", cnt_h, 0);
        chk_int("R6", "ordinary slice reads tap 1", cnt_b, 10);
        sub_qual_tap = 2'b10;
        idle(2);
        toggle(2, 20, 4'b0010, 4'b0010);
        chk_int("R7", "self tap replaced by high substitute", cnt_h, 10);

        // R8: internal divider, preset 3, pins toggling (ignored)
        cur_req = "R8";
        cfg_qual_mode = 2'd0;
        cfg_ext_clk = 1'b0;
        cfg_div_preset = 8'd3;
        cyc();
        cnt_h = 0;
        for (int i = 0; i < 40; i++) begin
            pin_in = pin_in ^ 4'b1111;
            cyc();
        end
        chk_int("R8", "divider events in 40 cycles, preset 3", cnt_h, 10);
        cfg_div_preset = 8'd0;
        idle(6);
        cnt_h = 0;
        idle(20);
        chk_int("R8", "divider events in 20 cycles, preset 0", cnt_h, 20);

        // R9: internal events gated by slice qualifier held low
        cur_req = "R9";
        cfg_qual_mode = 2'd2;
        cfg_qual_idx = 2'd0;
        qual_tap = 4'b0000;
        cyc();
        cnt_h = 0;
        idle(20);
        chk_int("R9", "internal events with low qualifier", cnt_h, 0);

        // R10: random configuration and inputs every cycle vs model
        cur_req = "R10";
        for (int i = 0; i < 600; i++) begin
            pin_in             = 4'($urandom);
            clk_tap            = 4'($urandom);
            qual_tap           = 4'($urandom);
            sub_qual_tap       = 2'($urandom);
            cfg_ext_clk        = ($urandom % 4) != 0;
            cfg_clk_from_slice = 1'($urandom);
            cfg_clk_idx        = 2'($urandom);
            cfg_fall_edge      = 1'($urandom);
            cfg_qual_mode      = 2'($urandom);
            cfg_qual_idx       = 2'($urandom);
            cfg_div_preset     = 8'($urandom % 6);
            cyc();
        end

        done = 1;
        summary();
        $finish;
    end

endmodule